// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block timestamps edges on an asynchronous input pin. The pin first passes through a two-flop synchronizer. A digital filter then accepts a new level only after that level has been seen on a run of consecutive samples, which rejects glitches and bounce shorter than the run. A polarity control picks either rising or falling transitions of the filtered level. An event divider can pass only every 2nd, 4th or 8th qualified transition.

Each surviving event copies the value on the running counter input into a capture register and raises a capture flag. If the flag is still set when the next capture arrives, an overcapture flag is also raised. Software can clear each flag with a one-cycle pulse. Software can also force a capture event, which bypasses the filter and the divider. The free-running counter lives outside the block and arrives on an input port.

Top module: `capture_channel`

## Requirements
- R1: While `rst` is high on a rising clock edge, `cap_val` becomes 0 and both `cap_flag` and `ovr_flag` become 0.
- R2: After the two synchronizer flops, the filtered level takes a new value only once that value has been sampled on N consecutive clocks. `flt_code` values 0, 1, 2 and 3 give N = 1, 2, 4 and 8. A pulse shorter than N clocks produces no event.
- R3: `edge_sel` = 0 qualifies low-to-high changes of the filtered level, and `edge_sel` = 1 qualifies high-to-low changes. Changes in the other direction produce no capture.
- R4: `div_code` values 0, 1, 2 and 3 pass every 1st, 2nd, 4th and 8th qualified edge. The edge count restarts from zero while `cap_en` is low.
- R5: A pin level held from before clock edge 1 is captured at edge N+3. At that edge, `cap_val` takes the `cnt_val` present at the edge.
- R6: While `cap_en` is low, pin activity changes neither `cap_val` nor `cap_flag`.
- R7: Every capture event sets `cap_flag`. A `clr_flag` pulse clears it, but a capture in the same cycle wins over the clear.
- R8: A capture event while `cap_flag` is already 1 sets `ovr_flag`. A `clr_ovr` pulse clears it, but a new overcapture in the same cycle wins over the clear.
- R9: `sw_gen` acts as a capture event on the next edge, without the filter or the divider, and updates both flags. It loads `cnt_val` into `cap_val` only when `cap_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous input being timed |
| cnt_val | input | CW | Running counter value |
| cap_en | input | 1 | Capture enable |
| edge_sel | input | 1 | 0 rising, 1 falling |
| flt_code | input | 2 | Filter run length code |
| div_code | input | 2 | Event divider code |
| sw_gen | input | 1 | Software capture request |
| clr_flag | input | 1 | Clear capture flag |
| clr_ovr | input | 1 | Clear overcapture flag |
| cap_val | output | CW | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
The bench uses several kinds of input pulse:
- Pulses shorter and longer than the filter run, at each filter code. These separate a correct run length from an off-by-one.
- Isolated transitions under both polarities. These show whether the wrong edge is ever taken.
- Trains of 3 and then 4 pulses with a divide-by-4 setting. These separate a correct divider from a neighbouring ratio.
- Back-to-back captures with and without clears in between, plus software requests with capture disabled. These separate the overcapture rule and the enable gating.

A behavioural model runs alongside and flags any output that differs in any cycle.

// File: rtl/capq_pkg.sv
package capq_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;

  // number of samples or events selected by a 2^code encoding
  function automatic logic [7:0] pow2_of(input logic [1:0] code);
    return 8'd1 << code;
  endfunction
endpackage

// File: rtl/capq_filter.sv
module capq_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic [CODE_W-1:0] flt_code,
  output logic              rise_p,
  output logic              fall_p
);
  localparam int MAXLOG = (1 << CODE_W) - 1;
  localparam int RUN_W  = (MAXLOG > 0) ? MAXLOG : 1;

  logic [SYNC_STAGES-1:0] sync_r;
  logic                   sync_q;
  logic                   lvl;
  logic [RUN_W-1:0]       run_cnt;
  logic [RUN_W:0]         need;
  logic [RUN_W:0]         run_nx;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sync_r <= '0;
        else     sync_r <= {sync_r[SYNC_STAGES-2:0], pin_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_r <= '0;
        else     sync_r <= pin_in;
      end
    end
  endgenerate

  assign sync_q = sync_r[SYNC_STAGES-1];
  assign need   = (RUN_W+1)'(1) << flt_code;
  assign run_nx = {1'b0, run_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl     <= 1'b0;
      run_cnt <= '0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (sync_q == lvl) begin
        run_cnt <= '0;
      end else if (run_nx >= need) begin
        lvl     <= sync_q;
        run_cnt <= '0;
        rise_p  <= sync_q;
        fall_p  <= ~sync_q;
      end else begin
        run_cnt <= run_nx[RUN_W-1:0];
      end
    end
  end

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_p, fall_p}));
  // R2
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_q == lvl) |=> $stable(lvl));
endmodule

// File: rtl/capq_evsel.sv
module capq_evsel #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              edge_sel,
  input  logic              cap_en,
  input  logic [CODE_W-1:0] div_code,
  output logic              cap_ev
);
  import capq_pkg::*;
  localparam int MAXLOG = (1 << CODE_W) - 1;
  localparam int DIV_W  = (MAXLOG > 0) ? MAXLOG : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             sel;

  assign sel      = (edge_e'(edge_sel) == EDGE_FALL) ? fall_p : rise_p;
  assign div_last = DIV_W'((DIV_W+1)'(1) << div_code) - 1'b1;
  assign cap_ev   = sel && cap_en && (div_cnt == div_last);

  always_ff @(posedge clk) begin
    if (rst || !cap_en) div_cnt <= '0;
    else if (sel)       div_cnt <= (div_cnt == div_last) ? '0 : div_cnt + 1'b1;
  end

  // R4
  div_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> (div_cnt == '0));
  // R3
  ev_src_chk: assert property (@(posedge clk) disable iff (rst)
    cap_ev |-> (rise_p || fall_p));
endmodule

// File: rtl/capq_latch.sv
module capq_latch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_ev,
  input  logic          sw_gen,
  input  logic          cap_en,
  input  logic [CW-1:0] cnt_val,
  input  logic          clr_flag,
  input  logic          clr_ovr,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovr_flag
);
  logic take;
  assign take = cap_ev || sw_gen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (take && cap_en) cap_val <= cnt_val;
      if (take)           cap_flag <= 1'b1;
      else if (clr_flag)  cap_flag <= 1'b0;
      if (take && cap_flag) ovr_flag <= 1'b1;
      else if (clr_ovr)     ovr_flag <= 1'b0;
    end
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> cap_flag);
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_flag && !take) |=> !cap_flag);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (take && cap_flag) |=> ovr_flag);
  // R5
  val_load_chk: assert property (@(posedge clk) disable iff (rst)
    (take && cap_en) |=> (cap_val == $past(cnt_val)));
  // R6
  val_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(cap_val));
endmodule

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int CW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_in,
  input  logic [CW-1:0] cnt_val,
  input  logic          cap_en,
  input  logic          edge_sel,
  input  logic [1:0]    flt_code,
  input  logic [1:0]    div_code,
  input  logic          sw_gen,
  input  logic          clr_flag,
  input  logic          clr_ovr,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovr_flag
);
  localparam int CODE_W = 2;

  logic rise_p, fall_p, cap_ev;

  capq_filter #(.SYNC_STAGES(SYNC_STAGES), .CODE_W(CODE_W)) u_flt (
    .clk(clk), .rst(rst), .pin_in(pin_in), .flt_code(flt_code),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  capq_evsel #(.CODE_W(CODE_W)) u_sel (
    .clk(clk), .rst(rst), .rise_p(rise_p), .fall_p(fall_p),
    .edge_sel(edge_sel), .cap_en(cap_en), .div_code(div_code), .cap_ev(cap_ev)
  );

  capq_latch #(.CW(CW)) u_lat (
    .clk(clk), .rst(rst), .cap_ev(cap_ev), .sw_gen(sw_gen), .cap_en(cap_en),
    .cnt_val(cnt_val), .clr_flag(clr_flag), .clr_ovr(clr_ovr),
    .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cap_val == '0 && !cap_flag && !ovr_flag));
endmodule

// File: tb/sim_capture_channel.sv
module sim_capture_channel;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_in = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic cap_en = 1'b1, edge_sel = 1'b0, sw_gen = 1'b0, clr_flag = 1'b0, clr_ovr = 1'b0;
  logic [1:0] flt_code = 2'd0, div_code = 2'd0;
  logic [CW-1:0] cap_val;
  logic cap_flag, ovr_flag;

  int total = 0, bad = 0, cyc = 0;
  bit live = 0;

  capture_channel #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cnt_val(cnt_val), .cap_en(cap_en),
    .edge_sel(edge_sel), .flt_code(flt_code), .div_code(div_code), .sw_gen(sw_gen),
    .clr_flag(clr_flag), .clr_ovr(clr_ovr),
    .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  always #2 clk = ~clk;

  // reference model state
  int m_s1, m_s2, m_lvl, m_run, m_rise, m_fall, m_div, m_flag, m_ovr;
  int m_cap;

  always @(posedge clk) begin
    int lim, sel, ev, take;
    live <= 1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_rise = 0; m_fall = 0;
      m_div = 0; m_flag = 0; m_ovr = 0; m_cap = 0;
    end else begin
      lim  = 1 << div_code;
      sel  = edge_sel ? m_fall : m_rise;
      ev   = (sel != 0 && cap_en && m_div == lim - 1) ? 1 : 0;
      take = (ev != 0 || sw_gen) ? 1 : 0;
      if (take != 0 && cap_en) m_cap = int'(cnt_val);
      if (take != 0 && m_flag != 0) m_ovr = 1;
      else if (clr_ovr) m_ovr = 0;
      if (take != 0) m_flag = 1;
      else if (clr_flag) m_flag = 0;
      if (!cap_en) m_div = 0;
      else if (sel != 0) m_div = (m_div == lim - 1) ? 0 : m_div + 1;
      m_rise = 0; m_fall = 0;
      if (m_s2 == m_lvl) m_run = 0;
      else if (m_run + 1 >= (1 << flt_code)) begin
        m_lvl = m_s2; m_run = 0; m_rise = m_s2; m_fall = 1 - m_s2;
      end else m_run = m_run + 1;
      m_s2 = m_s1;
      m_s1 = pin_in ? 1 : 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cnt_val <= cnt_val + 16'd7;
    cyc++;
    if (live) begin
      check(int'(cap_val) == m_cap, "R5 cap_val", int'(cap_val), m_cap);
      check(int'(cap_flag) == m_flag, "R7 cap_flag", int'(cap_flag), m_flag);
      check(int'(ovr_flag) == m_ovr, "R8 ovr_flag", int'(ovr_flag), m_ovr);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_flag = 1; clr_ovr = 1;
    @(negedge clk); clr_flag = 0; clr_ovr = 0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); pin_in = 1; idle(hi);
    pin_in = 0; idle(lo);
  endtask

  int keep;

  initial begin
    idle(3);
    // R1 reset state
    check(cap_val == 0, "R1 cap_val", int'(cap_val), 0);
    check(!cap_flag && !ovr_flag, "R1 flags", int'({cap_flag, ovr_flag}), 0);
    @(negedge clk); rst = 0;
    idle(4);

    // R2 filter: 8-sample run
    flt_code = 2'd3;
    pulse(5, 20);
    check(cap_flag == 0, "R2 short glitch rejected", int'(cap_flag), 0);
    pulse(12, 20);
    check(cap_flag == 1, "R2 long pulse accepted", int'(cap_flag), 1);
    clear_all();
    flt_code = 2'd1;
    pulse(1, 10);
    check(cap_flag == 0, "R2 1-clk glitch at N=2", int'(cap_flag), 0);
    pulse(2, 10);
    check(cap_flag == 1, "R2 2-clk pulse at N=2", int'(cap_flag), 1);
    clear_all();
    flt_code = 2'd2;
    pulse(3, 10);
    check(cap_flag == 0, "R2 3-clk glitch at N=4", int'(cap_flag), 0);
    pulse(4, 10);
    check(cap_flag == 1, "R2 4-clk pulse at N=4", int'(cap_flag), 1);
    clear_all();

    // R5 latency with N=1: capture at edge N+3
    flt_code = 2'd0;
    @(negedge clk); pin_in = 1;
    idle(3);
    check(cap_flag == 0, "R5 not yet at edge 3", int'(cap_flag), 0);
    idle(1);
    check(cap_flag == 1, "R5 captured at edge 4", int'(cap_flag), 1);
    pin_in = 0; idle(8);
    clear_all();

    // R3 falling edge selection
    edge_sel = 1;
    @(negedge clk); pin_in = 1; idle(10);
    check(cap_flag == 0, "R3 rising ignored when falling selected", int'(cap_flag), 0);
    pin_in = 0; idle(10);
    check(cap_flag == 1, "R3 falling captured", int'(cap_flag), 1);
    edge_sel = 0;
    clear_all();

    // R4 divide by 4
    cap_en = 0; idle(2); cap_en = 1;
    div_code = 2'd2;
    for (int k = 0; k < 3; k++) pulse(3, 6);
    check(cap_flag == 0, "R4 three edges at div4", int'(cap_flag), 0);
    pulse(3, 6);
    check(cap_flag == 1, "R4 fourth edge at div4", int'(cap_flag), 1);
    clear_all();
    div_code = 2'd1;
    pulse(3, 6);
    check(cap_flag == 0, "R4 first edge at div2", int'(cap_flag), 0);
    pulse(3, 6);
    check(cap_flag == 1, "R4 second edge at div2", int'(cap_flag), 1);
    div_code = 2'd0;
    clear_all();

    // R6 disabled: no capture from pin
    cap_en = 0;
    keep = int'(cap_val);
    pulse(4, 8); pulse(4, 8);
    check(int'(cap_val) == keep, "R6 value held", int'(cap_val), keep);
    check(cap_flag == 0, "R6 no flag", int'(cap_flag), 0);

    // R9 software request while disabled
    @(negedge clk); sw_gen = 1;
    @(negedge clk); sw_gen = 0;
    check(cap_flag == 1, "R9 sw flag", int'(cap_flag), 1);
    check(int'(cap_val) == keep, "R9 value held when disabled", int'(cap_val), keep);
    cap_en = 1;
    @(negedge clk); sw_gen = 1;
    @(negedge clk); sw_gen = 0;
    check(ovr_flag == 1, "R9 sw second request overcaptures", int'(ovr_flag), 1);
    clear_all();

    // R8 overcapture by pin, clear, and set-wins-over-clear
    pulse(3, 6);
    check(ovr_flag == 0, "R8 single capture", int'(ovr_flag), 0);
    pulse(3, 6);
    check(ovr_flag == 1, "R8 second capture", int'(ovr_flag), 1);
    @(negedge clk); clr_ovr = 1;
    @(negedge clk); clr_ovr = 0;
    check(ovr_flag == 0, "R8 cleared", int'(ovr_flag), 0);
    @(negedge clk); clr_ovr = 1; sw_gen = 1;
    @(negedge clk); clr_ovr = 0; sw_gen = 0;
    check(ovr_flag == 1, "R8 set wins over clear", int'(ovr_flag), 1);
    // R7 set wins over clear
    @(negedge clk); clr_flag = 1; sw_gen = 1;
    @(negedge clk); clr_flag = 0; sw_gen = 0;
    check(cap_flag == 1, "R7 set wins over clear", int'(cap_flag), 1);
    @(negedge clk); clr_flag = 1;
    @(negedge clk); clr_flag = 0;
    check(cap_flag == 0, "R7 cleared", int'(cap_flag), 0);

    idle(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule